// File: doc/BRIEF.md
# Buffered Parallel-to-Serial Shift Register

This block converts a parallel word into a serial bit stream through two registers. A holding register samples the parallel data pins on a rising edge of its own strobe. The shift register can be filled from that holding register, or it can be moved one stage at a time from a serial input on a second strobe. Only the last stage drives the serial output.

Both strobes and the two active-low controls (parallel fill and clear) are slow external signals. Each one passes through a synchronizer into a single system clock domain. The strobes are then turned into one-cycle enables by rising-edge detection. The fill and the clear act on their level, so they behave like the asynchronous controls of a discrete part, delayed only by the synchronizer. Holding fill and clear low together is illegal. In that case the clear wins, and a sticky flag records the event until system reset.

A typical use is a shadowed output port. Software-facing logic strobes a word into the holding register. Serial hardware later moves it out most-significant stage first, and it may chain further serial bits in behind it.

Top module: `buffered_piso`

## Requirements
- R1: A rising edge on `store_clk_i` copies `par_i` into the holding register, whatever the state of `load_n_i`, `clear_n_i` or `shift_clk_i`.
- R2: While `load_n_i` is low and `clear_n_i` is high, the shift register takes the holding register contents on every system clock, with no shift strobe needed.
- R3: When a `store_clk_i` rising edge arrives while `load_n_i` is low and `clear_n_i` is high, the newly sampled `par_i` enters the shift register in the same cycle as it enters the holding register.
- R4: While `clear_n_i` is low, every shift-register stage is zero. The holding register keeps its contents, so a later fill restores the stored word.
- R5: With `load_n_i` and `clear_n_i` both high, each `shift_clk_i` rising edge moves stage n-1 into stage n. Stage 0 takes `ser_i`, and `ser_o` shows stage WIDTH-1, so a filled word leaves most-significant bit first.
- R6: A `shift_clk_i` rising edge leaves the shift register unchanged while `load_n_i` or `clear_n_i` is low.
- R7: `load_n_i` and `clear_n_i` low together clear the shift register and set `illegal_o` to 1. The flag stays at 1 after both controls are released, until system reset.
- R8: With `rst` high at a clock edge, both registers, `ser_o` and `illegal_o` become 0.
- R9: A pin change seen at system clock edge k takes effect in the shift register at edge k+SYNC_STAGES. `ser_o` follows at edge k+SYNC_STAGES+1, one cycle after the internal update.
- R10: Each rising edge of a strobe acts exactly once, however many cycles the strobe stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| store_clk_i | input | 1 | Holding register strobe, acts on its rising edge |
| shift_clk_i | input | 1 | Shift strobe, acts on its rising edge |
| load_n_i | input | 1 | Active-low level fill of the shift register from the holding register |
| clear_n_i | input | 1 | Active-low clear of the shift register |
| par_i | input | WIDTH | Parallel data into the holding register |
| ser_i | input | 1 | Serial data into stage 0 |
| ser_o | output | 1 | Registered copy of the last stage |
| illegal_o | output | 1 | Sticky flag for fill and clear low together |

## Verification
The bench builds the block with WIDTH=8 and SYNC_STAGES=3. The deeper synchronizer makes the latency of R9 differ from the common two-stage case, so an off-by-one error in the synchronizer or edge-detect path shows up as a one-cycle slip on `ser_o`. The word width of eight lets a full serial readout of every stored pattern finish within a short directed sequence. The same parameters also allow a long random mix of strobes, fills, clears and illegal overlaps to be compared with the behavioural model on every clock.

// File: rtl/piso_pkg.sv
package piso_pkg;
   typedef enum logic [2:0] {
      ACT_HOLD,
      ACT_CLEAR,
      ACT_FILL,
      ACT_PASS,
      ACT_SHIFT
   } sr_act_e;
endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic async_i,
   output logic level_o
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("piso_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL}};
      else     chain <= {chain[STAGES-2:0], async_i};
   end

   assign level_o = chain[STAGES-1];
endmodule

// File: rtl/piso_edge.sv
module piso_edge (
   input  logic clk,
   input  logic rst,
   input  logic level_i,
   output logic rise_o
);
   logic prev;

   always_ff @(posedge clk) begin
      if (rst) prev <= 1'b0;
      else     prev <= level_i;
   end

   assign rise_o = level_i & ~prev;

   // R10: one enable per rising edge
   assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
      rise_o |=> !rise_o);
endmodule

// File: rtl/piso_store.sv
module piso_store #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cap_i,
   input  logic [WIDTH-1:0] din_i,
   output logic [WIDTH-1:0] q_o
);
   always_ff @(posedge clk) begin
      if (rst)        q_o <= '0;
      else if (cap_i) q_o <= din_i;
   end

   assert_capture_R1: assert property (@(posedge clk) disable iff (rst)
      cap_i |=> q_o == $past(din_i));
   assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
      !cap_i |=> $stable(q_o));
endmodule

// File: rtl/piso_shifter.sv
module piso_shifter
   import piso_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             st_rise_i,
   input  logic             sh_rise_i,
   input  logic             fill_n_i,
   input  logic             clr_n_i,
   input  logic [WIDTH-1:0] din_i,
   input  logic [WIDTH-1:0] held_i,
   input  logic             ser_i,
   output logic             msb_o,
   output logic             illegal_o
);
   sr_act_e          act;
   logic [WIDTH-1:0] sr;

   always_comb begin
      if (!clr_n_i)       act = ACT_CLEAR;
      else if (!fill_n_i) act = st_rise_i ? ACT_PASS : ACT_FILL;
      else if (sh_rise_i) act = ACT_SHIFT;
      else                act = ACT_HOLD;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sr <= '0;
      end else begin
         case (act)
            ACT_CLEAR: sr <= '0;
            ACT_FILL:  sr <= held_i;
            ACT_PASS:  sr <= din_i;
            ACT_SHIFT: sr <= {sr[WIDTH-2:0], ser_i};
            default:   sr <= sr;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst)                        illegal_o <= 1'b0;
      else if (!clr_n_i && !fill_n_i) illegal_o <= 1'b1;
   end

   assign msb_o = sr[WIDTH-1];

   assert_clear_zero_R4: assert property (@(posedge clk) disable iff (rst)
      !clr_n_i |=> sr == '0);
   assert_fill_follow_R2: assert property (@(posedge clk) disable iff (rst)
      (clr_n_i && !fill_n_i && !st_rise_i) |=> sr == $past(held_i));
   assert_pass_through_R3: assert property (@(posedge clk) disable iff (rst)
      (clr_n_i && !fill_n_i && st_rise_i) |=> sr == $past(din_i));
   assert_shift_step_R5: assert property (@(posedge clk) disable iff (rst)
      (clr_n_i && fill_n_i && sh_rise_i) |=>
         (sr[0] == $past(ser_i)) && (sr[WIDTH-1:1] == $past(sr[WIDTH-2:0])));
   assert_idle_stable_R6: assert property (@(posedge clk) disable iff (rst)
      (clr_n_i && fill_n_i && !sh_rise_i) |=> $stable(sr));
   assert_flag_set_R7: assert property (@(posedge clk) disable iff (rst)
      (!clr_n_i && !fill_n_i) |=> illegal_o);
   assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
      illegal_o |=> illegal_o);
endmodule

// File: rtl/buffered_piso.sv
module buffered_piso #(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             store_clk_i,
   input  logic             shift_clk_i,
   input  logic             load_n_i,
   input  logic             clear_n_i,
   input  logic [WIDTH-1:0] par_i,
   input  logic             ser_i,
   output logic             ser_o,
   output logic             illegal_o
);
   logic             st_lvl, sh_lvl, fill_n, clr_n;
   logic             st_rise, sh_rise;
   logic [WIDTH-1:0] held;
   logic             msb;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("buffered_piso: WIDTH must be at least 2");
      end
   endgenerate

   piso_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_st (
      .clk(clk), .rst(rst), .async_i(store_clk_i), .level_o(st_lvl));
   piso_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sh (
      .clk(clk), .rst(rst), .async_i(shift_clk_i), .level_o(sh_lvl));
   piso_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ld (
      .clk(clk), .rst(rst), .async_i(load_n_i), .level_o(fill_n));
   piso_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cl (
      .clk(clk), .rst(rst), .async_i(clear_n_i), .level_o(clr_n));

   piso_edge u_edge_st (.clk(clk), .rst(rst), .level_i(st_lvl), .rise_o(st_rise));
   piso_edge u_edge_sh (.clk(clk), .rst(rst), .level_i(sh_lvl), .rise_o(sh_rise));

   piso_store #(.WIDTH(WIDTH)) u_store (
      .clk(clk), .rst(rst), .cap_i(st_rise), .din_i(par_i), .q_o(held));

   piso_shifter #(.WIDTH(WIDTH)) u_shifter (
      .clk(clk), .rst(rst), .st_rise_i(st_rise), .sh_rise_i(sh_rise),
      .fill_n_i(fill_n), .clr_n_i(clr_n), .din_i(par_i), .held_i(held),
      .ser_i(ser_i), .msb_o(msb), .illegal_o(illegal_o));

   always_ff @(posedge clk) begin
      if (rst) ser_o <= 1'b0;
      else     ser_o <= msb;
   end

   // R9: output register trails the last stage by one cycle
   assert_out_delay_R9: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ser_o == $past(msb));
endmodule

// File: tb/buffered_piso_bench.sv
`timescale 1ns/1ps
module buffered_piso_bench;
   localparam int W = 8;
   localparam int S = 3;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         st = 1'b0, sh = 1'b0, ld_n = 1'b1, cl_n = 1'b1, sin = 1'b0;
   logic [W-1:0] din = '0;
   logic         ser_o, illegal_o;

   int  total = 0;
   int  bad = 0;
   bit  done = 0;
   bit  cmp_on = 0;

   always #2.5 clk = ~clk;

   buffered_piso #(.WIDTH(W), .SYNC_STAGES(S)) u_buffered_piso (
      .clk(clk), .rst(rst), .store_clk_i(st), .shift_clk_i(sh),
      .load_n_i(ld_n), .clear_n_i(cl_n), .par_i(din), .ser_i(sin),
      .ser_o(ser_o), .illegal_o(illegal_o));

   // behavioural reference: pin history delayed by S cycles, then the rules
   logic [W-1:0] m_store, m_sr;
   logic         m_ser, m_ill;
   bit           h_st[1:S+1], h_sh[1:S+1], h_ld[1:S+1], h_cl[1:S+1];

   always @(posedge clk) begin : model
      bit st_r, sh_r, f_n, c_n;
      if (rst) begin
         for (int i = 1; i <= S+1; i++) begin
            h_st[i] = 0; h_sh[i] = 0; h_ld[i] = 1; h_cl[i] = 1;
         end
         m_store = '0; m_sr = '0; m_ser = 0; m_ill = 0;
      end else begin
         st_r = h_st[S] && !h_st[S+1];
         sh_r = h_sh[S] && !h_sh[S+1];
         f_n  = h_ld[S];
         c_n  = h_cl[S];
         m_ser = m_sr[W-1];
         if (!c_n) begin
            m_sr = '0;
            if (!f_n) m_ill = 1;
         end else if (!f_n) begin
            m_sr = st_r ? din : m_store;
         end else if (sh_r) begin
            m_sr = {m_sr[W-2:0], sin};
         end
         if (st_r) m_store = din;
         for (int i = S+1; i >= 2; i--) begin
            h_st[i] = h_st[i-1]; h_sh[i] = h_sh[i-1];
            h_ld[i] = h_ld[i-1]; h_cl[i] = h_cl[i-1];
         end
         h_st[1] = st; h_sh[1] = sh; h_ld[1] = ld_n; h_cl[1] = cl_n;
      end
   end

   task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (cmp_on && !rst) begin
         chk("R9 ser_o per cycle", {{(W-1){1'b0}}, ser_o}, {{(W-1){1'b0}}, m_ser});
         chk("R7 illegal_o per cycle", {{(W-1){1'b0}}, illegal_o}, {{(W-1){1'b0}}, m_ill});
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic capture(input logic [W-1:0] v);
      din = v; st = 1; idle(4); st = 0; idle(4);
   endtask

   task automatic shift_pulse(input logic b, input int hold);
      sin = b; sh = 1; idle(hold); sh = 0; idle(4);
   endtask

   task automatic fill_pulse();
      ld_n = 0; idle(S+4); ld_n = 1; idle(S+4);
   endtask

   task automatic read_word(output logic [W-1:0] v);
      v = '0;
      for (int i = 0; i < W; i++) begin
         idle(6);
         v = {v[W-2:0], ser_o};
         shift_pulse(1'b0, 2);
      end
   endtask

   initial begin : watchdog
      #(5.0 * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : stim
      logic [W-1:0] r;
      idle(3); rst = 0; idle(1);
      cmp_on = 1;
      // R8 reset state
      chk("R8 ser_o after reset", {{(W-1){1'b0}}, ser_o}, '0);
      chk("R8 illegal_o after reset", {{(W-1){1'b0}}, illegal_o}, '0);

      // R1 capture, R2 level fill
      capture(8'hA5); fill_pulse(); read_word(r);
      chk("R1/R2 fill from holding register", r, 8'hA5);

      // R3 capture during fill passes straight through
      capture(8'h11); ld_n = 0; idle(S+4);
      capture(8'h3C); ld_n = 1; idle(S+4); read_word(r);
      chk("R3 pass-through during fill", r, 8'h3C);

      // R4 clear zeroes shift register, holding register kept
      capture(8'hF0); fill_pulse();
      cl_n = 0; idle(S+4); cl_n = 1; idle(S+4);
      read_word(r); chk("R4 clear result", r, 8'h00);
      fill_pulse(); read_word(r); chk("R4 holding kept after clear", r, 8'hF0);

      // R5 serial in
      for (int i = 0; i < W; i++) shift_pulse(((8'hB2 >> (W-1-i)) & 1) != 0, 2);
      read_word(r); chk("R5 serial shift in", r, 8'hB2);

      // R6 shift ignored while clear low, and while fill low
      cl_n = 0; idle(S+4);
      shift_pulse(1'b1, 2); shift_pulse(1'b1, 2);
      cl_n = 1; idle(S+4);
      read_word(r); chk("R6 shifts ignored during clear", r, 8'h00);
      capture(8'h0F); ld_n = 0; idle(S+4);
      shift_pulse(1'b1, 2); shift_pulse(1'b1, 2);
      idle(2);
      chk("R6 shifts ignored during fill", {{(W-1){1'b0}}, ser_o}, '0);
      ld_n = 1; idle(S+4);
      read_word(r); chk("R6 word intact after fill", r, 8'h0F);

      // R10 long shift strobe acts once
      capture(8'h81); fill_pulse();
      shift_pulse(1'b1, 20);
      read_word(r); chk("R10 one shift per strobe edge", r, 8'h03);

      // R9 latency: pin change before edge k, ser_o changes after edge k+S+1
      capture(8'h80);
      ld_n = 0;
      idle(S+1);
      chk("R9 ser_o before latency", {{(W-1){1'b0}}, ser_o}, '0);
      idle(1);
      chk("R9 ser_o at latency", {{(W-1){1'b0}}, ser_o}, 8'h01);
      ld_n = 1; idle(S+4);

      // R7 illegal combination
      ld_n = 0; cl_n = 0; idle(S+4);
      chk("R7 flag raised", {{(W-1){1'b0}}, illegal_o}, 8'h01);
      ld_n = 1; cl_n = 1; idle(S+4);
      chk("R7 flag sticky", {{(W-1){1'b0}}, illegal_o}, 8'h01);
      read_word(r); chk("R7 clear wins", r, 8'h00);
      rst = 1; idle(2); rst = 0; idle(1);
      chk("R8 reset clears flag", {{(W-1){1'b0}}, illegal_o}, '0);

      // random mix, compared every cycle by the model
      for (int n = 0; n < 3000; n++) begin
         case ($urandom_range(0, 5))
            0: st = ~st;
            1: sh = ~sh;
            2: ld_n = ~ld_n;
            3: cl_n = ($urandom_range(0, 3) == 0) ? 1'b0 : 1'b1;
            default: ;
         endcase
         din = W'($urandom);
         sin = 1'($urandom);
         idle($urandom_range(1, 5));
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule